// File: doc/BRIEF.md
# Signed Array Multiplier with Complemented-Row Sign Handling

This block multiplies two two's-complement operands and returns their full-width signed product. It forms one partial-product row for each bit of the first operand. Each row is the AND of that bit with every bit of the second operand, shifted left by the bit's index. The rows are summed as plain unsigned bit vectors. The sign is handled by complementing selected row bits and seeding the sum with two constant ones, so the adder never sign-extends and never subtracts.

The multiplier core is pure combinational logic. A parameter chooses whether the product passes through a single output register. The default build registers it, which gives one cycle of latency. The register has a synchronous active-low reset. With the defaults, the operands are 8 bits and the product is 16 bits. Any carry out of the top product bit is dropped.

Top module: `sam_mult`

## Requirements
- R1: With the output register present, `prod` after each rising clock edge equals the signed product of the `op_a` and `op_b` values sampled at that edge, reduced modulo 2^16. This holds for every one of the 65536 operand pairs, with all operands read as two's complement.
- R2: The pair -128 × -128 (0x80, 0x80) yields +16384 (0x4000).
- R3: The pair -128 × 127 (0x80, 0x7F) yields -16256 (0xC080), and 127 × -128 yields the same value.
- R4: When either operand is zero, the product is 0x0000 one cycle later.
- R5: The product is exactly 16 bits wide and any carry beyond bit 15 is discarded. As an example, -1 × -1 (0xFF, 0xFF) yields 0x0001, even though the internal row sum carries past bit 15.
- R6: A change of operands shows at `prod` only after the next rising edge. Between the change and that edge, `prod` keeps the previous product.
- R7: While `rst_n` is low at a rising edge, `prod` becomes 0x0000 whatever the operands are. Reset takes priority over capturing a new product.
- R8: While the operands are held constant outside reset, `prod` stays constant from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| op_a | input | 8 | Multiplicand, two's complement |
| op_b | input | 8 | Multiplier, two's complement |
| prod | output | 16 | Signed product, two's complement |

## Verification
Two events can fall on the same clock edge: a reset, and the capture of a freshly changed operand pair. The bench applies nonzero operands while `rst_n` is low, so both land on one edge. It then expects 0x0000, not the product. After release, the bench expects the product on the first edge only. The full sweep then covers every operand pair. Each pair is compared one edge after it is applied against the product of the integers computed in the bench. This also covers the most negative operand and the case where the internal sum carries out of the top bit.

// File: rtl/sam_pkg.sv
// Package sam_pkg
// Shared constants for the signed array multiplier.
// Assumes operand widths of at least 2 bits.
package sam_pkg;
    localparam int unsigned SAM_DEF_N = 8;
endpackage

// File: rtl/sam_pp_rows.sv
// Module sam_pp_rows
// Builds the N partial-product rows. Row i holds a[i] AND b[j] for every j.
// In rows 0..N-2 the top bit is complemented. In the last row every bit
// except the top one is complemented. No shifting happens here; the
// summing stage applies the row offsets.
// Assumes N >= 2.
module sam_pp_rows #(
    parameter int unsigned N = sam_pkg::SAM_DEF_N
) (
    input  logic [N-1:0]        a,
    input  logic [N-1:0]        b,
    output logic [N-1:0][N-1:0] rows
);
    localparam int unsigned LAST = N - 1;

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_bit
            localparam bit FLIP = ((i != LAST) && (j == LAST)) ||
                                  ((i == LAST) && (j != LAST));
            if (FLIP) begin : g_inv
                // complemented AND term
                assign rows[i][j] = ~(a[i] & b[j]);
            end else begin : g_pass
                // plain AND term
                assign rows[i][j] = a[i] & b[j];
            end
        end
    end
endmodule

// File: rtl/sam_row_sum.sv
// Module sam_row_sum
// Adds the shifted rows to a seed holding constant ones at bit N and
// bit 2N-1. The adds form a linear chain. The result is truncated to 2N
// bits, so any carry out of the top bit is lost.
// Assumes the rows arrive with the complement pattern already applied.
module sam_row_sum #(
    parameter int unsigned N = sam_pkg::SAM_DEF_N
) (
    input  logic [N-1:0][N-1:0] rows,
    output logic [2*N-1:0]      sum
);
    localparam int unsigned PW = 2 * N;
    localparam logic [PW-1:0] SEED = (PW'(1) << N) | (PW'(1) << (PW - 1));

    logic [PW-1:0] acc [N+1];

    // seed the chain with the two correction ones
    assign acc[0] = SEED;

    for (genvar i = 0; i < N; i++) begin : g_add
        logic [PW-1:0] placed;
        // widen the row and move it to its weight
        assign placed     = {{N{1'b0}}, rows[i]} << i;
        // accumulate one row per stage
        assign acc[i + 1] = acc[i] + placed;
    end

    assign sum = acc[N];
endmodule

// File: rtl/sam_out_stage.sv
// Module sam_out_stage
// Optional output register. With REG=1 it is a flop with a synchronous
// active-low reset; with REG=0 it is a wire.
module sam_out_stage #(
    parameter int unsigned W   = 16,
    parameter bit          REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (REG) begin : g_reg
        // capture the product, clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end
    end else begin : g_wire
        logic unused_ok;
        // pass straight through when no register is wanted
        assign q = d;
        assign unused_ok = clk ^ rst_n;
    end
endmodule

// File: rtl/sam_mult.sv
// Module sam_mult
// Top level of the signed array multiplier. It connects row generation,
// the row sum and the optional output register.
// Assumes two's-complement operands; the product is 2N bits.
module sam_mult #(
    parameter int unsigned N       = sam_pkg::SAM_DEF_N,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [2*N-1:0] prod
);
    localparam int unsigned PW = 2 * N;

    logic [N-1:0][N-1:0] rows;
    logic [PW-1:0]       raw;

    sam_pp_rows #(.N(N)) u_rows (
        .a    (op_a),
        .b    (op_b),
        .rows (rows)
    );

    sam_row_sum #(.N(N)) u_sum (
        .rows (rows),
        .sum  (raw)
    );

    sam_out_stage #(.W(PW), .REG(OUT_REG)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (prod)
    );
endmodule

// File: rtl/sam_mult_chk.sv
// Module sam_mult_chk
// Property checker for sam_mult. It is active only when the output
// register is present.
module sam_mult_chk #(
    parameter int unsigned N       = 8,
    parameter bit          OUT_REG = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic [2*N-1:0] prod
);
    localparam int unsigned PW = 2 * N;

    logic [PW-1:0] ref_p;
    // behavioural signed product for comparison
    assign ref_p = PW'($signed(op_a) * $signed(op_b));

    if (OUT_REG) begin : g_chk
        p_signed_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (prod == $past(ref_p)));
        p_zero_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((op_a == '0) || (op_b == '0)) |=> (prod == '0));
        p_one_cycle_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && ((op_a != $past(op_a)) || (op_b != $past(op_b))))
            |=> (prod == $past(ref_p)));
        p_reset_clears_r7: assert property (@(posedge clk)
            (!rst_n) |=> (prod == '0));
        p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $stable(op_a) && $stable(op_b)) |=> $stable(prod));
    end
endmodule

bind sam_mult sam_mult_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_a  (op_a),
    .op_b  (op_b),
    .prod  (prod)
);

// File: tb/tb_sam_mult.sv
module tb_sam_mult;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_a = 8'h00;
    logic [7:0]  op_b = 8'h00;
    logic [15:0] prod;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    sam_mult dut (
        .clk   (clk),
        .rst_n (rst_n),
        .op_a  (op_a),
        .op_b  (op_b),
        .prod  (prod)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [15:0] expect_p(input logic [7:0] x, input logic [7:0] y);
        int p;
        p = int'($signed(x)) * int'($signed(y));
        return p[15:0];
    endfunction

    task automatic check(input string req, input logic [15:0] exp_v);
        total++;
        if (prod !== exp_v) begin
            bad++;
            $display("FAIL %s: prod=%h expected=%h (a=%h b=%h)", req, prod, exp_v, op_a, op_b);
        end
    endtask

    // drive at negedge, pass one posedge, sample at the following negedge
    task automatic apply(input logic [7:0] x, input logic [7:0] y);
        op_a = x;
        op_b = y;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        // R7: reset and an operand change land on the same edge
        op_a = 8'h35;
        op_b = 8'h7B;
        @(posedge clk);
        @(negedge clk);
        check("R7", 16'h0000);
        op_a = 8'h80;
        op_b = 8'h81;
        @(posedge clk);
        @(negedge clk);
        check("R7", 16'h0000);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R7", expect_p(8'h80, 8'h81));

        apply(8'h80, 8'h80); check("R2", 16'h4000);
        apply(8'h80, 8'h7F); check("R3", 16'hC080);
        apply(8'h7F, 8'h80); check("R3", 16'hC080);
        apply(8'h00, 8'h80); check("R4", 16'h0000);
        apply(8'hFF, 8'h00); check("R4", 16'h0000);
        apply(8'hFF, 8'hFF); check("R5", 16'h0001);
        apply(8'h7F, 8'h7F); check("R5", 16'h3F01);

        // R6: before the next edge the old product remains
        apply(8'h05, 8'hFD);
        op_a = 8'h11;
        op_b = 8'h22;
        #1;
        check("R6", expect_p(8'h05, 8'hFD));
        @(posedge clk);
        @(negedge clk);
        check("R6", expect_p(8'h11, 8'h22));

        // R8: held operands leave the product unchanged
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R8", expect_p(8'h11, 8'h22));
        end

        // R1: every operand pair
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                apply(8'(i), 8'(j));
                check("R1", expect_p(8'(i), 8'(j)));
            end
        end

        // R7: reset in mid-run clears the output
        op_a = 8'hC3;
        op_b = 8'h5A;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7", 16'h0000);
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule